// File: doc/BRIEF.md
# Two-Wire Slave Command Engine for a Quad Digital Potentiometer

This block is the bus-facing controller of a four-channel digitally controlled potentiometer. It oversamples an open-drain two-wire bus (serial clock and serial data) with the system clock. It finds start and stop conditions and checks the slave address against four strap inputs. It then decodes an instruction byte that names an operation, one of four potentiometers and one of four stored data registers. It answers with acknowledge bits and, for reads, shifts a byte out on the data line. Finished instructions are handed to the register and wiper logic as commands on a valid/ready stream.

Every transaction starts with an address byte and an instruction byte. Transfer instructions end there. Register and wiper writes take one more data byte, and reads return one. The step instruction opens a free-running phase that lasts until the next stop or start. In that phase each serial clock pulse moves the selected wiper one segment, in the direction given by the data line level. While the storage behind the block reports a nonvolatile write in progress, the address byte is not acknowledged. The bus master therefore polls with start plus address until an acknowledge comes back.

The command stream holds one entry. A command stays valid, with a stable payload, until it is accepted. Because the bus master cannot be stalled, a byte that would produce a command while the entry is still occupied is answered with no acknowledge, and a step pulse that arrives while it is occupied is discarded. Read data is supplied combinationally by the storage through `rd_data`, selected by `rd_pot`, `rd_sel` and `rd_from_dr`.

Top module: `twp_cmd_engine`

## Requirements
- R1: After reset the data line is released (`sda_oe` low) and `cmd_valid` is low.
- R2: A falling data line while the clock is high is a start; a rising data line while the clock is high is a stop. Bits clocked before any start draw no acknowledge and produce no command, and a stop returns the engine to idle with the data line released.
- R3: The address byte is acknowledged (data line held low during the ninth clock) only when bits 7..4 equal 0101 and bits 3..0 equal `dev_addr`. Otherwise it is not acknowledged and the bus is ignored until the next start.
- R4: While `nv_busy` is high a matching address byte is not acknowledged. Once `nv_busy` is low again, the same address is acknowledged.
- R5: The instruction byte holds the opcode in bits 7..4, the potentiometer number in bits 3..2 and the data register number in bits 1..0. The only valid opcodes are 0001, 0010, 1000, 1001, 1010, 1011, 1100, 1101 and 1110. Any other opcode is not acknowledged and produces no command.
- R6: The transfer opcodes 1101, 1110, 0001 and 1000 complete with the instruction byte. Their command carries the opcode, potentiometer and register fields and is issued during the instruction acknowledge.
- R7: The write opcodes 1010 (wiper) and 1100 (data register) take a data byte. That byte is acknowledged, and its command carries the opcode, the fields and the byte in `cmd_data`.
- R8: The read opcodes 1001 (wiper) and 1011 (data register) drive `rd_pot` and `rd_sel` from the instruction and drive `rd_from_dr` high only for 1011. After the instruction acknowledge, `rd_data` is shifted out MSB first, each bit changed after the clock falls. The data line is then released for the master's acknowledge bit and the engine returns to idle.
- R9: After opcode 0010 is acknowledged, every clock high pulse until the next stop or start issues a step command (opcode 0010) for the selected potentiometer. `cmd_data[0]` is 1 (toward the high terminal) when the data line was high and 0 when it was low. After the stop, clock pulses issue nothing.
- R10: A start in any state abandons the current transaction without issuing its command, and address reception begins again.
- R11: `cmd_valid` with `cmd_ready` low keeps `cmd_valid` high and the payload unchanged. While an entry is pending, an instruction or data byte that would issue a command is not acknowledged, and step pulses are dropped.
- R12: The engine starts pulling the data line low only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| sda_oe | output | 1 | High pulls the data line low |
| dev_addr | input | 4 | Strap value matched against address bits 3..0 |
| nv_busy | input | 1 | Nonvolatile write in progress; address is refused |
| rd_pot | output | 2 | Potentiometer selected for a read |
| rd_sel | output | 2 | Data register selected for a read |
| rd_from_dr | output | 1 | High: read a data register; low: read the wiper register |
| rd_data | input | 8 | Read value returned by storage for the current selection |
| cmd_valid | output | 1 | A command is pending |
| cmd_ready | input | 1 | Consumer accepts the pending command |
| cmd_op | output | 4 | Command opcode |
| cmd_pot | output | 2 | Command potentiometer number |
| cmd_sel | output | 2 | Command data register number |
| cmd_data | output | 8 | Written byte, or step direction in bit 0 |

## Verification
On every cycle the assertions check several properties. A start always leads to address reception, and a stop always releases the line and idles the engine. The engine never pushes into an occupied command entry, and a pending command holds still under back-pressure. Only valid opcodes reach the stream, a busy flag forces a refused address, and the data line is never newly pulled low while the clock is high. The bench scenarios show what no single-cycle property can: that every strap/address pairing and every one of the sixteen opcodes gets the right acknowledge, that read bytes come out in the right bit order for every selection, that step directions follow the data line pulse by pulse, and that an aborted write leaves no command behind.

// File: rtl/twp_pkg.sv
package twp_pkg;

  localparam int BYTE_W = 8;
  localparam int OP_W   = 4;
  localparam int POT_W  = 2;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  localparam logic [OP_W-1:0] OP_GLOAD   = 4'b0001;
  localparam logic [OP_W-1:0] OP_STEP    = 4'b0010;
  localparam logic [OP_W-1:0] OP_GSAVE   = 4'b1000;
  localparam logic [OP_W-1:0] OP_RD_WIP  = 4'b1001;
  localparam logic [OP_W-1:0] OP_WR_WIP  = 4'b1010;
  localparam logic [OP_W-1:0] OP_RD_DAT  = 4'b1011;
  localparam logic [OP_W-1:0] OP_WR_DAT  = 4'b1100;
  localparam logic [OP_W-1:0] OP_LOAD    = 4'b1101;
  localparam logic [OP_W-1:0] OP_SAVE    = 4'b1110;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [POT_W-1:0]  pot;
    logic [SEL_W-1:0]  sel;
    logic [BYTE_W-1:0] data;
  } cmd_t;

  function automatic logic op_is_xfer(input logic [OP_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_SAVE) || (op == OP_GLOAD) || (op == OP_GSAVE);
  endfunction

  function automatic logic op_is_write(input logic [OP_W-1:0] op);
    return (op == OP_WR_WIP) || (op == OP_WR_DAT);
  endfunction

  function automatic logic op_is_read(input logic [OP_W-1:0] op);
    return (op == OP_RD_WIP) || (op == OP_RD_DAT);
  endfunction

  function automatic logic op_valid(input logic [OP_W-1:0] op);
    return op_is_xfer(op) || op_is_write(op) || op_is_read(op) || (op == OP_STEP);
  endfunction

endpackage

// File: rtl/twp_bus_sync.sv
module twp_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_p;
  logic              sda_p;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[i] <= 1'b1;
            sda_q[i] <= 1'b1;
          end else begin
            scl_q[i] <= scl_i;
            sda_q[i] <= sda_i;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            scl_q[i] <= 1'b1;
            sda_q[i] <= 1'b1;
          end else begin
            scl_q[i] <= scl_q[i-1];
            sda_q[i] <= sda_q[i-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/twp_cmd_slot.sv
module twp_cmd_slot
  import twp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  cmd_t push_cmd,
  input  logic cmd_ready,
  output logic cmd_valid,
  output cmd_t cmd_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_out   <= '0;
    end else if (push && !cmd_valid) begin
      cmd_valid <= 1'b1;
      cmd_out   <= push_cmd;
    end else if (cmd_valid && cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  // R11
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_out));

  // R11
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !cmd_valid);

endmodule

// File: rtl/twp_proto_fsm.sv
module twp_proto_fsm
  import twp_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [3:0]        dev_addr,
  input  logic              nv_busy,
  input  logic              slot_full,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_low,
  output logic              push,
  output cmd_t              push_cmd,
  output logic [POT_W-1:0]  rd_pot,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_from_dr
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INSTR, ST_WDATA, ST_READ, ST_STEP
  } st_e;

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  st_e               state;
  st_e               next_st;
  logic [CNT_W-1:0]  bitcnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] tx;
  logic              ackph;
  logic [OP_W-1:0]   iop;
  logic [POT_W-1:0]  ipot;
  logic [SEL_W-1:0]  isel;

  logic              ev_ack;
  logic              ev_push;
  st_e               ev_nx;
  cmd_t              ev_cmd;
  logic              rx_state;
  logic [OP_W-1:0]   sh_op;

  assign sh_op    = shreg[BYTE_W-1 -: OP_W];
  assign rx_state = (state == ST_ADDR) || (state == ST_INSTR) || (state == ST_WDATA);

  // decision taken on the falling edge that opens the acknowledge bit
  always_comb begin
    ev_ack  = 1'b0;
    ev_push = 1'b0;
    ev_nx   = ST_IDLE;
    ev_cmd  = '0;
    case (state)
      ST_ADDR: begin
        ev_ack = (shreg[7:4] == DEV_TYPE) && (shreg[3:0] == dev_addr) && !nv_busy;
        ev_nx  = ST_INSTR;
      end
      ST_INSTR: begin
        ev_cmd.op  = sh_op;
        ev_cmd.pot = shreg[3:2];
        ev_cmd.sel = shreg[1:0];
        if (op_is_read(sh_op)) begin
          ev_ack = 1'b1;
          ev_nx  = ST_READ;
        end else if (op_is_write(sh_op)) begin
          ev_ack = 1'b1;
          ev_nx  = ST_WDATA;
        end else if (sh_op == OP_STEP) begin
          ev_ack = 1'b1;
          ev_nx  = ST_STEP;
        end else if (op_is_xfer(sh_op)) begin
          ev_ack  = !slot_full;
          ev_push = !slot_full;
          ev_nx   = ST_IDLE;
        end
      end
      ST_WDATA: begin
        ev_ack      = !slot_full;
        ev_push     = !slot_full;
        ev_cmd.op   = iop;
        ev_cmd.pot  = ipot;
        ev_cmd.sel  = isel;
        ev_cmd.data = shreg;
        ev_nx       = ST_IDLE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      next_st  <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      tx       <= '0;
      ackph    <= 1'b0;
      sda_low  <= 1'b0;
      push     <= 1'b0;
      push_cmd <= '0;
      iop      <= '0;
      ipot     <= '0;
      isel     <= '0;
    end else begin
      push <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        ackph   <= 1'b0;
        sda_low <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bitcnt  <= '0;
        ackph   <= 1'b0;
        sda_low <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INSTR, ST_WDATA: begin
            if (scl_rise && !ackph && bitcnt != LAST_BIT) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end
            if (scl_fall) begin
              if (ackph) begin
                ackph  <= 1'b0;
                bitcnt <= '0;
                state  <= next_st;
                if (next_st == ST_READ) begin
                  sda_low <= ~rd_data[BYTE_W-1];
                  tx      <= {rd_data[BYTE_W-2:0], 1'b0};
                end else begin
                  sda_low <= 1'b0;
                end
              end else if (bitcnt == LAST_BIT) begin
                ackph    <= 1'b1;
                sda_low  <= ev_ack;
                next_st  <= ev_ack ? ev_nx : ST_IDLE;
                push     <= ev_push;
                push_cmd <= ev_cmd;
                if (state == ST_INSTR) begin
                  iop  <= sh_op;
                  ipot <= shreg[3:2];
                  isel <= shreg[1:0];
                end
              end
            end
          end
          ST_READ: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            if (scl_fall) begin
              if (bitcnt < LAST_BIT) begin
                sda_low <= ~tx[BYTE_W-1];
                tx      <= {tx[BYTE_W-2:0], 1'b0};
              end else if (bitcnt == LAST_BIT) begin
                sda_low <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_STEP: begin
            if (scl_rise && !slot_full) begin
              push          <= 1'b1;
              push_cmd.op   <= OP_STEP;
              push_cmd.pot  <= ipot;
              push_cmd.sel  <= isel;
              push_cmd.data <= {{(BYTE_W-1){1'b0}}, sda_s};
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign rd_pot     = ipot;
  assign rd_sel     = isel;
  assign rd_from_dr = (iop == OP_RD_DAT);

  // R2 R10
  start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR && !sda_low);

  // R2
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE && !sda_low);

  // R4
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_ADDR && scl_fall && !ackph && bitcnt == LAST_BIT && nv_busy && !start_det && !stop_det
    |=> !sda_low && next_st == ST_IDLE);

  // R5
  only_valid_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> op_valid(push_cmd.op));

  // R12
  drive_low_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !scl_s);

  // R9
  step_only_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && push_cmd.op == OP_STEP && !rx_state |-> $past(state) == ST_STEP);

endmodule

// File: rtl/twp_cmd_engine.sv
module twp_cmd_engine
  import twp_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [3:0]        dev_addr,
  input  logic              nv_busy,
  output logic [POT_W-1:0]  rd_pot,
  output logic [SEL_W-1:0]  rd_sel,
  output logic              rd_from_dr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [OP_W-1:0]   cmd_op,
  output logic [POT_W-1:0]  cmd_pot,
  output logic [SEL_W-1:0]  cmd_sel,
  output logic [BYTE_W-1:0] cmd_data
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic push;
  cmd_t push_cmd;
  cmd_t cmd_out;

  twp_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twp_proto_fsm #(.DEV_TYPE(DEV_TYPE)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .sda_s      (sda_s),
    .dev_addr   (dev_addr),
    .nv_busy    (nv_busy),
    .slot_full  (cmd_valid),
    .rd_data    (rd_data),
    .sda_low    (sda_oe),
    .push       (push),
    .push_cmd   (push_cmd),
    .rd_pot     (rd_pot),
    .rd_sel     (rd_sel),
    .rd_from_dr (rd_from_dr)
  );

  twp_cmd_slot u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_cmd  (push_cmd),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_out   (cmd_out)
  );

  assign cmd_op   = cmd_out.op;
  assign cmd_pot  = cmd_out.pot;
  assign cmd_sel  = cmd_out.sel;
  assign cmd_data = cmd_out.data;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !sda_oe && !cmd_valid);

endmodule

// File: tb/twp_cmd_engine_tb.sv
`timescale 1ns/1ps
module twp_cmd_engine_tb;

  localparam int Q  = 6;
  localparam int WD = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [3:0] strap = 4'hA;
  logic nv_busy = 1'b0;
  logic cmd_ready = 1'b1;
  logic sda_oe, bus_sda;
  logic [1:0] rd_pot, rd_sel, cmd_pot, cmd_sel;
  logic rd_from_dr, cmd_valid;
  logic [7:0] rd_data, cmd_data;
  logic [3:0] cmd_op;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int cap_cnt = 0;
  logic [3:0] cap_op;
  logic [1:0] cap_pot, cap_sel;
  logic [7:0] cap_data;
  logic dirs [0:31];

  always #4 clk = ~clk;

  assign bus_sda = sda_m & ~sda_oe;
  assign rd_data = {rd_from_dr, rd_pot, rd_sel, 3'b101};

  twp_cmd_engine u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_m),
    .sda_i      (bus_sda),
    .sda_oe     (sda_oe),
    .dev_addr   (strap),
    .nv_busy    (nv_busy),
    .rd_pot     (rd_pot),
    .rd_sel     (rd_sel),
    .rd_from_dr (rd_from_dr),
    .rd_data    (rd_data),
    .cmd_valid  (cmd_valid),
    .cmd_ready  (cmd_ready),
    .cmd_op     (cmd_op),
    .cmd_pot    (cmd_pot),
    .cmd_sel    (cmd_sel),
    .cmd_data   (cmd_data)
  );

  always @(posedge clk) begin
    if (rst_n && cmd_valid && cmd_ready) begin
      cap_cnt  <= cap_cnt + 1;
      cap_op   <= cmd_op;
      cap_pot  <= cmd_pot;
      cap_sel  <= cmd_sel;
      cap_data <= cmd_data;
      dirs[cap_cnt[4:0]] <= cmd_data[0];
    end
  end

  function automatic bit exp_valid(input logic [3:0] op);
    return op inside {4'b0001, 4'b0010, 4'b1000, 4'b1001, 4'b1010,
                      4'b1011, 4'b1100, 4'b1101, 4'b1110};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_q(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(1);
    scl_m = 1'b1; wait_q(2);
    sda_m = 1'b0; wait_q(2);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(1);
    scl_m = 1'b1; wait_q(2);
    sda_m = 1'b1; wait_q(2);
  endtask

  task automatic clock_bit(input logic b, output logic r);
    sda_m = b;    wait_q(1);
    scl_m = 1'b1; wait_q(1);
    r = bus_sda;  wait_q(1);
    scl_m = 1'b0; wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], r);
    clock_bit(1'b1, r);
    ack = !r;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic mack);
    logic r;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      clock_bit(1'b1, r);
      d = {d[6:0], r};
    end
    clock_bit(!mack, r);
  endtask

  task automatic open_txn(input logic [3:0] op, input logic [1:0] pot, input logic [1:0] sel,
                          output logic a_ack, output logic i_ack);
    bus_start();
    send_byte({4'b0101, strap}, a_ack);
    send_byte({op, pot, sel}, i_ack);
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic a, i, d_ack, r;
    logic [7:0] d;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    chk(cmd_valid == 1'b0, "R1 no command", cmd_valid, 0);

    // R2 bits before any start are ignored
    scl_m = 1'b0; wait_q(1);
    send_byte({4'b0101, strap}, a);
    chk(a == 1'b0, "R2 no ack before start", a, 0);
    chk(cap_cnt == 0, "R2 no command before start", cap_cnt, 0);

    // R3 address sweep
    for (int n = 0; n < 16; n++) begin
      bus_start();
      send_byte({4'b0101, 4'(n)}, a);
      chk(a == (4'(n) == strap), "R3 address match", a, (4'(n) == strap));
      bus_stop();
    end
    bus_start();
    send_byte({4'b0011, strap}, a);
    chk(a == 1'b0, "R3 wrong device type", a, 0);
    send_byte({4'b1101, 4'b0000}, a);
    chk(a == 1'b0 && cap_cnt == 0, "R3 ignored after refused address", a, 0);
    bus_stop();

    // R4 busy polling
    nv_busy = 1'b1;
    bus_start();
    send_byte({4'b0101, strap}, a);
    chk(a == 1'b0, "R4 busy refuses address", a, 0);
    bus_stop();
    nv_busy = 1'b0;
    bus_start();
    send_byte({4'b0101, strap}, a);
    chk(a == 1'b1, "R4 idle accepts address", a, 1);
    bus_stop();

    // R5 R6 R7 R8 opcode sweep
    for (int op = 0; op < 16; op++) begin
      logic [3:0] o;
      o = 4'(op);
      base = cap_cnt;
      open_txn(o, 2'd1, 2'd2, a, i);
      chk(a, "R3 address in sweep", a, 1);
      chk(i == exp_valid(o), "R5 opcode acknowledge", i, exp_valid(o));
      if (o == 4'b1010 || o == 4'b1100) begin
        send_byte(8'h5C ^ {4'h0, o}, d_ack);
        chk(d_ack == 1'b1, "R7 data byte ack", d_ack, 1);
        chk(cap_cnt == base + 1 && cap_op == o && cap_pot == 2'd1 && cap_sel == 2'd2
            && cap_data == (8'h5C ^ {4'h0, o}), "R7 write command", cap_data, 8'h5C ^ {4'h0, o});
      end else if (o == 4'b1001 || o == 4'b1011) begin
        recv_byte(d, 1'b1);
        chk(d == {(o == 4'b1011), 2'd1, 2'd2, 3'b101}, "R8 read value", d,
            {(o == 4'b1011), 2'd1, 2'd2, 3'b101});
      end else if (o inside {4'b0001, 4'b1000, 4'b1101, 4'b1110}) begin
        chk(cap_cnt == base + 1 && cap_op == o && cap_pot == 2'd1 && cap_sel == 2'd2,
            "R6 transfer command", cap_op, o);
      end else if (o != 4'b0010) begin
        chk(cap_cnt == base, "R5 no command for bad opcode", cap_cnt - base, 0);
      end
      bus_stop();
    end

    // R7 write sweep over every pot and register
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        logic [7:0] v;
        v = {2'(p), 2'(s), ~2'(p), ~2'(s)};
        base = cap_cnt;
        open_txn(4'b1100, 2'(p), 2'(s), a, i);
        send_byte(v, d_ack);
        chk(d_ack && cap_cnt == base + 1 && cap_op == 4'b1100 && cap_pot == 2'(p)
            && cap_sel == 2'(s) && cap_data == v, "R7 data register write", cap_data, v);
        bus_stop();
      end
    end

    // R8 read sweep, both sources
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 2; k++) begin
          logic [7:0] e;
          e = {k[0], 2'(p), 2'(s), 3'b101};
          open_txn(k[0] ? 4'b1011 : 4'b1001, 2'(p), 2'(s), a, i);
          recv_byte(d, 1'b1);
          chk(d == e, "R8 read byte MSB first", d, e);
          chk(sda_oe == 1'b0, "R8 released after read", sda_oe, 0);
          bus_stop();
        end
      end
    end

    // R9 step sequence
    base = cap_cnt;
    open_txn(4'b0010, 2'd3, 2'd0, a, i);
    chk(i == 1'b1, "R9 step command ack", i, 1);
    clock_bit(1'b1, r); clock_bit(1'b1, r); clock_bit(1'b0, r);
    clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b0, r);
    chk(cap_cnt == base + 6, "R9 one step per pulse", cap_cnt - base, 6);
    chk(cap_op == 4'b0010 && cap_pot == 2'd3, "R9 step fields", cap_op, 2);
    chk(dirs[(base + 0) % 32] == 1 && dirs[(base + 1) % 32] == 1 && dirs[(base + 2) % 32] == 0
        && dirs[(base + 3) % 32] == 1 && dirs[(base + 4) % 32] == 0 && dirs[(base + 5) % 32] == 0,
        "R9 step directions", dirs[(base + 2) % 32], 0);
    bus_stop();
    base = cap_cnt;
    scl_m = 1'b0; wait_q(1);
    clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b1, r);
    chk(cap_cnt == base, "R9 no steps after stop", cap_cnt - base, 0);
    scl_m = 1'b1; wait_q(1);

    // R10 repeated start aborts a write
    base = cap_cnt;
    open_txn(4'b1010, 2'd2, 2'd0, a, i);
    clock_bit(1'b1, r); clock_bit(1'b0, r); clock_bit(1'b1, r); clock_bit(1'b1, r);
    bus_start();
    send_byte({4'b0101, strap}, a);
    chk(a == 1'b1, "R10 address after restart", a, 1);
    send_byte({4'b1101, 2'd0, 2'd3}, i);
    chk(cap_cnt == base + 1 && cap_op == 4'b1101, "R10 aborted write dropped", cap_op, 4'hD);
    bus_stop();

    // R11 back-pressure
    cmd_ready = 1'b0;
    base = cap_cnt;
    open_txn(4'b1110, 2'd0, 2'd3, a, i);
    chk(i == 1'b1, "R11 first command accepted", i, 1);
    bus_stop();
    chk(cmd_valid && cmd_op == 4'b1110 && cmd_sel == 2'd3, "R11 pending held", cmd_op, 4'hE);
    open_txn(4'b0001, 2'd0, 2'd1, a, i);
    chk(i == 1'b0, "R11 full slot refuses", i, 0);
    bus_stop();
    open_txn(4'b0010, 2'd1, 2'd0, a, i);
    clock_bit(1'b1, r); clock_bit(1'b0, r);
    bus_stop();
    chk(cmd_valid && cmd_op == 4'b1110 && cmd_pot == 2'd0, "R11 payload stable", cmd_op, 4'hE);
    cmd_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(cap_cnt == base + 1 && cap_op == 4'b1110 && cap_sel == 2'd3, "R11 drained once",
        cap_cnt - base, 1);
    chk(cmd_valid == 1'b0, "R11 slot empty", cmd_valid, 0);

    // R12 bus released at end
    chk(sda_oe == 1'b0, "R12 line released when idle", sda_oe, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule